// File: doc/BRIEF.md
# Camera Power-Sense Status Controller

This block works out what kind of camera sits at the far end of a cable that can deliver supply power. It uses two digital comparator flags. One flag reports a shorted sense pair, which marks a camera that takes no power. The other reports the small sense voltage that a power-accepting camera develops. The block scans until one of the two flags settles. It then turns on the 12 V enable only for a power-accepting camera. After that it waits for a live camera pixel clock. A two-colour indicator (amber, green) shows progress. A colour flashes while the block waits for the clock and shows solid once the clock is present.

The block keeps the camera state only while the clock stays valid. If the clock is lost in a locked state, the block goes back to scanning and drops power, so a different kind of camera can be connected. Both sense flags pass through a synchroniser and a debounce filter before they can change the state. The pixel clock is sampled into the system clock domain and judged by an inactivity timeout.

Top module: `cps_status_ctrl`

## Requirements
- R1: In reset and in the scanning state, amber, green and the power enable are all low.
- R2: From scanning, a filtered shorted-pair flag selects the non-powered wait state. Amber flashes, green is off and power stays off.
- R3: In the non-powered wait state, a valid camera clock moves the block to solid amber, with power still off.
- R4: From scanning, a filtered powered-sense flag with no short flag raises the power enable and flashes green.
- R5: In the powered wait state, a valid camera clock moves the block to solid green, with power kept on.
- R6: In solid amber or solid green, loss of clock validity returns the block to scanning the next cycle. All outputs fall low.
- R7: When both sense flags are set in scanning, the shorted flag wins. The block enters the non-powered wait state and power is never enabled.
- R8: A sense flag change is accepted only after the synchronised value has differed from the filtered level for DEB_CYC consecutive cycles. Shorter pulses have no effect.
- R9: Wait and locked states ignore sense flag changes. Wait states leave only on a valid clock, and locked states leave only on clock loss.
- R10: The clock is valid from the cycle after a synchronised rising pix_clk_i edge. It becomes invalid after CLK_TIMEOUT cycles with no rising edge.
- R11: A flashing colour is a square wave, on for FLASH_HALF cycles and then off for FLASH_HALF cycles. Any window of 2*FLASH_HALF cycles shows exactly FLASH_HALF on-cycles.
- R12: Amber and green are never on in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| short_sense_i | input | 1 | Comparator flag: sense pair shorted (non-powered camera) |
| pwr_sense_i | input | 1 | Comparator flag: powered-camera sense voltage present |
| pix_clk_i | input | 1 | Camera pixel clock, asynchronous |
| amber_o | output | 1 | Amber indicator drive |
| green_o | output | 1 | Green indicator drive |
| pwr_en_o | output | 1 | 12 V power enable to the cable |

## Verification
The bench builds the block with DEB_CYC=4, CLK_TIMEOUT=16 and FLASH_HALF=5. It runs the pixel clock at one edge every three system cycles. These values bring every state, every transition and every clock loss within a few dozen cycles. A 2-cycle sense pulse falls below the debounce threshold. A 20-cycle sampling window covers exactly two flash periods, so the count of on-cycles tells off, solid and flashing apart.

// File: rtl/cps_pkg.sv
package cps_pkg;

  typedef enum logic [2:0] {
    ST_SCAN    = 3'd0,
    ST_NP_WAIT = 3'd1,
    ST_NP_LOCK = 3'd2,
    ST_PW_WAIT = 3'd3,
    ST_PW_LOCK = 3'd4
  } cam_st_e;

  typedef struct packed {
    logic amber;
    logic green;
    logic pwr;
  } ind_t;

  function automatic logic is_locked(cam_st_e s);
    return (s == ST_NP_LOCK) || (s == ST_PW_LOCK);
  endfunction

  function automatic logic is_flashing(cam_st_e s);
    return (s == ST_NP_WAIT) || (s == ST_PW_WAIT);
  endfunction

  // Output decode: ph is the flash phase (1 = lit)
  function automatic ind_t drive_of(cam_st_e s, logic ph);
    ind_t d;
    d = '0;
    case (s)
      ST_NP_WAIT: d.amber = ph;
      ST_NP_LOCK: d.amber = 1'b1;
      ST_PW_WAIT: begin d.green = ph;   d.pwr = 1'b1; end
      ST_PW_LOCK: begin d.green = 1'b1; d.pwr = 1'b1; end
      default:    d = '0;
    endcase
    return d;
  endfunction

  // Next state: shorted flag has priority over powered sense
  function automatic cam_st_e next_state(cam_st_e s, logic sh, logic pw, logic ck);
    cam_st_e n;
    n = s;
    case (s)
      ST_SCAN: begin
        if (sh)      n = ST_NP_WAIT;
        else if (pw) n = ST_PW_WAIT;
      end
      ST_NP_WAIT: if (ck)  n = ST_NP_LOCK;
      ST_PW_WAIT: if (ck)  n = ST_PW_LOCK;
      ST_NP_LOCK: if (!ck) n = ST_SCAN;
      ST_PW_LOCK: if (!ck) n = ST_SCAN;
      default:    n = ST_SCAN;
    endcase
    return n;
  endfunction

  // Debounce counter step: returns 1 when the threshold is reached
  function automatic logic deb_done(int unsigned cnt, int unsigned limit);
    return cnt == (limit - 1);
  endfunction

endpackage

// File: rtl/cps_sense_filter.sv
module cps_sense_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int DEB_CYC     = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_i,
  output logic level_o
);
  import cps_pkg::*;

  localparam int CW = $clog2(DEB_CYC + 1);

  logic [SYNC_STAGES-1:0] chain_q;
  logic [CW-1:0]          cnt_q;
  logic                   sync_w;
  logic                   differ_w;
  logic                   accept_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[SYNC_STAGES-2:0], raw_i};
  end

  assign sync_w   = chain_q[SYNC_STAGES-1];
  assign differ_w = (sync_w != level_o);
  assign accept_w = differ_w && deb_done(int'(cnt_q), DEB_CYC);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      level_o <= 1'b0;
    end else if (!differ_w) begin
      cnt_q   <= '0;
    end else if (accept_w) begin
      cnt_q   <= '0;
      level_o <= sync_w;
    end else begin
      cnt_q   <= cnt_q + 1'b1;
    end
  end

  AST_DEB_FOLLOWS_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    (level_o != $past(level_o)) |-> (level_o == $past(sync_w))); // R8
  AST_DEB_FULL_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (level_o != $past(level_o)) |-> ($past(cnt_q) == CW'(DEB_CYC - 1))); // R8

endmodule

// File: rtl/cps_clk_monitor.sv
module cps_clk_monitor #(
  parameter int SYNC_STAGES = 2,
  parameter int CLK_TIMEOUT = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pix_clk_i,
  output logic edge_o,
  output logic valid_o
);
  localparam int IW = $clog2(CLK_TIMEOUT + 1);

  logic [SYNC_STAGES:0] chain_q;
  logic [IW-1:0]        idle_q;
  logic                 expire_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[SYNC_STAGES-1:0], pix_clk_i};
  end

  assign edge_o   = chain_q[SYNC_STAGES-1] & ~chain_q[SYNC_STAGES];
  assign expire_w = (idle_q == IW'(CLK_TIMEOUT - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idle_q  <= '0;
      valid_o <= 1'b0;
    end else if (edge_o) begin
      idle_q  <= '0;
      valid_o <= 1'b1;
    end else if (valid_o) begin
      if (expire_w) begin
        valid_o <= 1'b0;
        idle_q  <= '0;
      end else begin
        idle_q  <= idle_q + 1'b1;
      end
    end
  end

  AST_EDGE_VALIDATES: assert property (@(posedge clk) disable iff (!rst_n)
    edge_o |=> valid_o); // R10
  AST_TIMEOUT_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !edge_o && expire_w) |=> !valid_o); // R10

endmodule

// File: rtl/cps_flasher.sv
module cps_flasher #(
  parameter int FLASH_HALF = 25_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  output logic phase_o
);
  localparam int FW = $clog2(FLASH_HALF + 1);

  logic [FW-1:0] cnt_q;
  logic          wrap_w;

  assign wrap_w = (cnt_q == FW'(FLASH_HALF - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      phase_o <= 1'b1;
    end else if (!en_i) begin
      cnt_q   <= '0;
      phase_o <= 1'b1;
    end else if (wrap_w) begin
      cnt_q   <= '0;
      phase_o <= ~phase_o;
    end else begin
      cnt_q   <= cnt_q + 1'b1;
    end
  end

  AST_FLASH_HALF_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && $past(en_i) && (phase_o != $past(phase_o))) |-> ($past(cnt_q) == FW'(FLASH_HALF - 1))); // R11

endmodule

// File: rtl/cps_status_ctrl.sv
module cps_status_ctrl #(
  parameter int SYNC_STAGES = 2,
  parameter int DEB_CYC     = 8,
  parameter int CLK_TIMEOUT = 1024,
  parameter int FLASH_HALF  = 25_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic short_sense_i,
  input  logic pwr_sense_i,
  input  logic pix_clk_i,
  output logic amber_o,
  output logic green_o,
  output logic pwr_en_o
);
  import cps_pkg::*;

  cam_st_e st_q;
  cam_st_e st_d;
  logic    short_f;
  logic    pwr_f;
  logic    clk_ok;
  logic    pix_edge;
  logic    flash_ph;
  logic    evt_clk_lost;
  ind_t    drv;

  cps_sense_filter #(.SYNC_STAGES(SYNC_STAGES), .DEB_CYC(DEB_CYC)) u_short (
    .clk(clk), .rst_n(rst_n), .raw_i(short_sense_i), .level_o(short_f));

  cps_sense_filter #(.SYNC_STAGES(SYNC_STAGES), .DEB_CYC(DEB_CYC)) u_pwr (
    .clk(clk), .rst_n(rst_n), .raw_i(pwr_sense_i), .level_o(pwr_f));

  cps_clk_monitor #(.SYNC_STAGES(SYNC_STAGES), .CLK_TIMEOUT(CLK_TIMEOUT)) u_clkmon (
    .clk(clk), .rst_n(rst_n), .pix_clk_i(pix_clk_i), .edge_o(pix_edge), .valid_o(clk_ok));

  cps_flasher #(.FLASH_HALF(FLASH_HALF)) u_flash (
    .clk(clk), .rst_n(rst_n), .en_i(is_flashing(st_q)), .phase_o(flash_ph));

  assign st_d         = next_state(st_q, short_f, pwr_f, clk_ok);
  assign evt_clk_lost = is_locked(st_q) && !clk_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_SCAN;
    else        st_q <= st_d;
  end

  assign drv      = drive_of(st_q, flash_ph);
  assign amber_o  = drv.amber;
  assign green_o  = drv.green;
  assign pwr_en_o = drv.pwr;

  AST_SCAN_DARK: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_SCAN) |-> (!amber_o && !green_o && !pwr_en_o)); // R1
  AST_SHORT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_SCAN && short_f) |=> (!pwr_en_o && st_q == ST_NP_WAIT)); // R7
  AST_PWR_AFTER_SENSE: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_SCAN && !short_f && pwr_f) |=> pwr_en_o); // R4
  AST_LOSS_TO_SCAN: assert property (@(posedge clk) disable iff (!rst_n)
    evt_clk_lost |=> (st_q == ST_SCAN && !pwr_en_o)); // R6
  AST_WAIT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (is_flashing(st_q) && !clk_ok) |=> $stable(st_q)); // R9
  AST_COLOURS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(amber_o && green_o)); // R12

endmodule

// File: tb/tb_cps_status_ctrl.sv
module tb_cps_status_ctrl;

  localparam int DEB  = 4;
  localparam int TMO  = 16;
  localparam int HALF = 5;
  localparam int WIN  = 4 * HALF;
  localparam int NV   = 13;

  // {short, pwr, clk_run, amber_mode[1:0], green_mode[1:0], pwr_exp}
  // mode: 0 = off, 1 = solid, 2 = flashing
  localparam logic [7:0] VEC [0:NV-1] = '{
    8'b000_00_00_0,  // R1 scanning
    8'b100_10_00_0,  // R2 short -> flash amber
    8'b101_01_00_0,  // R3 clock -> solid amber
    8'b001_01_00_0,  // R9 sense removed, stays locked
    8'b000_00_00_0,  // R6 clock lost -> scan
    8'b010_00_10_1,  // R4 powered sense -> power, flash green
    8'b011_00_01_1,  // R5 clock -> solid green
    8'b001_00_01_1,  // R9 sense removed, stays locked
    8'b000_00_00_0,  // R6 clock lost -> scan, power off
    8'b110_10_00_0,  // R7 both flags -> non-powered
    8'b000_10_00_0,  // R9 wait state holds without sense
    8'b001_01_00_0,  // R10 clock edges -> valid
    8'b000_00_00_0   // R10 timeout -> scan
  };

  function automatic string row_tag(int i);
    case (i)
      0: return "R1";  1: return "R2";  2: return "R3";  3: return "R9";
      4: return "R6";  5: return "R4";  6: return "R5";  7: return "R9";
      8: return "R6";  9: return "R7";  10: return "R9"; 11: return "R10";
      default: return "R10";
    endcase
  endfunction

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic short_sense = 1'b0;
  logic pwr_sense = 1'b0;
  logic pix_clk = 1'b0;
  logic pix_run = 1'b0;
  logic amber, green, pwr_en;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  initial forever begin
    #30;
    if (pix_run) pix_clk = ~pix_clk;
  end

  cps_status_ctrl #(.SYNC_STAGES(2), .DEB_CYC(DEB), .CLK_TIMEOUT(TMO), .FLASH_HALF(HALF)) dut (
    .clk(clk), .rst_n(rst_n), .short_sense_i(short_sense), .pwr_sense_i(pwr_sense),
    .pix_clk_i(pix_clk), .amber_o(amber), .green_o(green), .pwr_en_o(pwr_en));

  task automatic check(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic int ones_for_mode(int m);
    case (m)
      0: return 0;
      1: return WIN;
      default: return WIN / 2;
    endcase
  endfunction

  // sample WIN cycles at the falling edge, count lit cycles
  task automatic measure(string tag, int exp_a, int exp_g, int exp_p);
    int na = 0, ng = 0, np = 0, both = 0;
    for (int k = 0; k < WIN; k++) begin
      @(negedge clk);
      na += int'(amber); ng += int'(green); np += int'(pwr_en);
      both += int'(amber && green);
    end
    check(tag, "amber on-cycles", na, ones_for_mode(exp_a));
    check(tag, "green on-cycles", ng, ones_for_mode(exp_g));
    check(tag, "power on-cycles", np, exp_p ? WIN : 0);
    check("R12", "cycles with both colours", both, 0);
  endtask

  task automatic settle(int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  initial begin
    int wd = 0;
    while (wd < 100000) begin @(posedge clk); wd++; end
    failures++;
    checks++;
    $display("FAIL watchdog expired actual=%0d expected=<%0d", wd, 100000);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    settle(3);
    check("R1", "amber in reset", int'(amber), 0);
    check("R1", "green in reset", int'(green), 0);
    check("R1", "power in reset", int'(pwr_en), 0);
    rst_n = 1'b1;
    settle(5);

    for (int i = 0; i < NV; i++) begin
      short_sense = VEC[i][7];
      pwr_sense   = VEC[i][6];
      pix_run     = VEC[i][5];
      settle(60);
      measure(row_tag(i), int'(VEC[i][4:3]), int'(VEC[i][2:1]), int'(VEC[i][0]));
    end

    // R8: pulses shorter than the debounce threshold are ignored
    @(negedge clk); short_sense = 1'b1;
    settle(2);       short_sense = 1'b0;
    settle(30);
    measure("R8", 0, 0, 0);
    @(negedge clk); pwr_sense = 1'b1;
    settle(2);       pwr_sense = 1'b0;
    settle(30);
    measure("R8", 0, 0, 0);

    // R11: flashing green from first entry, lit for exactly HALF cycles first
    @(negedge clk); pwr_sense = 1'b1;
    begin
      int waited = 0;
      while (!pwr_en && waited < 50) begin @(negedge clk); waited++; end
      for (int k = 0; k < HALF; k++) begin
        check("R11", "green lit in first half-period", int'(green), 1);
        @(negedge clk);
      end
      check("R11", "green dark after half-period", int'(green), 0);
    end

    // R1: reset from a powered state removes power at once
    pix_run = 1'b1;
    settle(40);
    rst_n = 1'b0;
    #1;
    check("R1", "power during reset", int'(pwr_en), 0);
    check("R1", "green during reset", int'(green), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule